// File: doc/BRIEF.md
# Three-Channel PCM Serial Port

This block is the digital serial side of a three-channel voice codec. It moves 8-bit companded samples between per-channel parallel registers and open-drain serial lines. It runs on the bit clock. A transmit sync and a separate receive sync mark the start of each frame, and each sync is recognised on its rising edge. A static lane-mode input selects the layout. In split mode every channel has its own serial input and output lane. In burst mode the channel-0 lane carries all three samples back to back as one 24-bit burst.

On the transmit side, the block loads one byte per channel from a parallel bus when a frame starts and shifts it out MSB first. Each output lane is modelled as an active-low output enable, so the pin is driven low only for a 0 bit inside the lane's own slot. Everywhere else the external pull-up holds the pin at 1. A global power input and per-channel enables force the line into the released state or replace the sample with the idle code. On the receive side, each completed byte appears on a per-channel parallel output with a one-cycle valid strobe.

Top module: `pcm_serial_port`

## Requirements
- R1: In split mode (burst_mode_i=0), lane c carries channel c only. Bit 7 (MSB) is on the line in the cycle after the clock edge that samples the rise of tx_sync_i, followed by bits 6 down to 0 in the next seven cycles.
- R2: In burst mode (burst_mode_i=1), lane 0 carries 24 bits: channel 0, then channel 1, then channel 2, each MSB first. Output lanes 1 and 2 stay released, and serial inputs 1 and 2 have no effect on any received byte.
- R3: The transmitted bytes, the channel enables and the mode are taken at the edge that starts the frame. Changing tx_data_i after that edge does not alter the bits of that frame.
- R4: The rise of rx_sync_i is sampled at edge k. Received bits are sampled at edges k+1 to k+8, MSB first. The byte appears on rx_data_o[c*8 +: 8] with rx_valid_o[c] high for exactly one cycle, the cycle after edge k+8. In burst mode, channel c completes after edge k+8(c+1) and takes bits 8c to 8c+7 of lane 0.
- R5: tx_oe_no[c] is 0 only when lane c is inside its active slot and the current bit is 0. In every cycle outside the 8-bit (split) or 24-bit (burst) slot, it is 1.
- R6: While pwr_up_i is 0, all tx_oe_no bits are 1 at once, including in the middle of a slot.
- R7: With pwr_up_i=1 and ch_en_i[c]=0 at frame start, channel c sends the idle code 11111111 (positive zero), so its pin stays high for the whole slot.
- R8: After reset, tx_oe_no is all ones, rx_valid_o is zero and rx_data_o is zero.
- R9: A sync held high for many cycles starts only one frame. Only a new rising edge starts another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_mode_i | input | 1 | 0: split lanes, 1: 24-bit burst on lane 0 |
| pwr_up_i | input | 1 | Global power; 0 releases all serial outputs |
| ch_en_i | input | 3 | Per-channel enable; 0 sends the idle code |
| tx_sync_i | input | 1 | Transmit frame sync, rising edge starts a frame |
| tx_data_i | input | 24 | Transmit bytes, channel c at [c*8 +: 8] |
| tx_oe_no | output | 3 | Open-drain enable per lane, 0 pulls the pin low |
| rx_sync_i | input | 1 | Receive frame sync, rising edge marks the MSB |
| rx_sd_i | input | 3 | Serial data input per lane |
| rx_data_o | output | 24 | Received bytes, channel c at [c*8 +: 8] |
| rx_valid_o | output | 3 | One-cycle strobe per channel on a new byte |

## Verification
A table of frames runs both modes with all channels enabled, with a mix of enabled and disabled channels, and with global power off. This separates lane routing, burst ordering and the idle-code substitution. Every frame changes tx_data_i right after the start edge, so the bench can tell whether the frame was latched at the start or read live. In burst frames, inputs 1 and 2 carry patterns that differ from lane 0, which would expose any path from the ignored inputs. Directed frames hold a sync high past the slot and drop power mid-slot, covering the edge-only start and the immediate release.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned DEF_CH = 3;
  localparam int unsigned DEF_W  = 8;

  typedef enum logic {
    LANE_SPLIT = 1'b0,
    LANE_BURST = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/pcm_slot_cnt.sv
module pcm_slot_cnt
  import pcm_port_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CH,
  parameter int unsigned W      = DEF_W,
  localparam int unsigned BURST = NUM_CH * W,
  localparam int unsigned CNT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             mode_i,
  output logic             start_o,
  output logic             active_o,
  output logic             burst_o,
  output logic [CNT_W-1:0] idx_o
);
  logic       sync_q;
  lane_mode_e mode_q;
  logic [CNT_W-1:0] last_idx;

  assign start_o  = sync_i & ~sync_q;
  assign burst_o  = (mode_q == LANE_BURST);
  assign last_idx = burst_o ? CNT_W'(BURST - 1) : CNT_W'(W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      active_o <= 1'b0;
      idx_o    <= '0;
      mode_q   <= LANE_SPLIT;
    end else begin
      sync_q <= sync_i;
      if (start_o) begin
        active_o <= 1'b1;
        idx_o    <= '0;
        mode_q   <= lane_mode_e'(mode_i);
      end else if (active_o) begin
        if (idx_o == last_idx) begin
          active_o <= 1'b0;
          idx_o    <= '0;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end

  // R5
  slot_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !burst_o) |-> (idx_o < CNT_W'(W)));

  // R9
  held_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && sync_i && active_o && idx_o == last_idx) |=> !active_o);
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_port_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CH,
  parameter int unsigned W      = DEF_W,
  localparam int unsigned BURST = NUM_CH * W,
  localparam int unsigned CNT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_up_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [BURST-1:0]  data_i,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              burst_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [NUM_CH-1:0] oe_no
);
  // channel 0 occupies the top byte so burst order is a plain MSB-first walk
  logic [BURST-1:0] frame_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned SLOT_LO = (NUM_CH - 1 - c) * W;
    localparam logic [CNT_W-1:0] BASE = CNT_W'((NUM_CH - c) * W - 1);
    logic [CNT_W-1:0] pos;
    logic             lane_on;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        frame_q[SLOT_LO +: W] <= '1;
      else if (start_i)
        frame_q[SLOT_LO +: W] <= (pwr_up_i && ch_en_i[c]) ? data_i[c*W +: W] : '1;
    end

    assign pos     = BASE - idx_i;
    assign lane_on = burst_i ? (c == 0) : 1'b1;
    assign oe_no[c] = ~(pwr_up_i && active_i && lane_on && !frame_q[pos]);
  end

  // R5
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (&oe_no));

  // R6
  pwr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |-> (&oe_no));

  if (NUM_CH > 1) begin : g_quiet
    // R2
    burst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      burst_i |-> (&oe_no[NUM_CH-1:1]));
  end
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
  import pcm_port_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CH,
  parameter int unsigned W      = DEF_W,
  localparam int unsigned BURST = NUM_CH * W,
  localparam int unsigned CNT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] sd_i,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              burst_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [BURST-1:0]  data_o,
  output logic [NUM_CH-1:0] valid_o
);
  logic [W-2:0] sh_q [NUM_CH];

  for (genvar l = 0; l < NUM_CH; l++) begin : g_lane
    logic [W-1:0] nxt;
    assign nxt = {sh_q[l], sd_i[l]};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sh_q[l] <= '0;
      else if (start_i)  sh_q[l] <= '0;
      else if (active_i) sh_q[l] <= nxt[W-2:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [CNT_W-1:0] END_BURST = CNT_W'((c + 1) * W - 1);
    localparam logic [CNT_W-1:0] END_SPLIT = CNT_W'(W - 1);
    logic         cap;
    logic [W-1:0] word;

    assign cap  = active_i && (idx_i == (burst_i ? END_BURST : END_SPLIT));
    // burst mode reads only lane 0; the other inputs never reach the word
    assign word = burst_i ? {sh_q[0], sd_i[0]} : {sh_q[c], sd_i[c]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[c*W +: W] <= '0;
        valid_o[c]       <= 1'b0;
      end else begin
        valid_o[c] <= cap;
        if (cap) data_o[c*W +: W] <= word;
      end
    end

    // R4
    rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o[c] |=> !valid_o[c]);
  end

  // R2
  burst_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(burst_i) |-> $onehot0(valid_o));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CH,
  parameter int unsigned W      = DEF_W,
  localparam int unsigned BURST = NUM_CH * W,
  localparam int unsigned CNT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burst_mode_i,
  input  logic              pwr_up_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              tx_sync_i,
  input  logic [BURST-1:0]  tx_data_i,
  output logic [NUM_CH-1:0] tx_oe_no,
  input  logic              rx_sync_i,
  input  logic [NUM_CH-1:0] rx_sd_i,
  output logic [BURST-1:0]  rx_data_o,
  output logic [NUM_CH-1:0] rx_valid_o
);
  logic             tx_start, tx_active, tx_burst;
  logic [CNT_W-1:0] tx_idx;
  logic             rx_start, rx_active, rx_burst;
  logic [CNT_W-1:0] rx_idx;

  pcm_slot_cnt #(.NUM_CH(NUM_CH), .W(W)) u_tx_slot (
    .clk_i, .rst_ni, .sync_i(tx_sync_i), .mode_i(burst_mode_i),
    .start_o(tx_start), .active_o(tx_active), .burst_o(tx_burst), .idx_o(tx_idx)
  );

  pcm_slot_cnt #(.NUM_CH(NUM_CH), .W(W)) u_rx_slot (
    .clk_i, .rst_ni, .sync_i(rx_sync_i), .mode_i(burst_mode_i),
    .start_o(rx_start), .active_o(rx_active), .burst_o(rx_burst), .idx_o(rx_idx)
  );

  pcm_tx #(.NUM_CH(NUM_CH), .W(W)) u_tx (
    .clk_i, .rst_ni, .pwr_up_i, .ch_en_i, .data_i(tx_data_i),
    .start_i(tx_start), .active_i(tx_active), .burst_i(tx_burst), .idx_i(tx_idx),
    .oe_no(tx_oe_no)
  );

  pcm_rx #(.NUM_CH(NUM_CH), .W(W)) u_rx (
    .clk_i, .rst_ni, .sd_i(rx_sd_i),
    .start_i(rx_start), .active_i(rx_active), .burst_i(rx_burst), .idx_i(rx_idx),
    .data_o(rx_data_o), .valid_o(rx_valid_o)
  );
endmodule

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_mode = 1'b0, pwr_up = 1'b0;
  logic [2:0]  ch_en = '0;
  logic        tx_sync = 1'b0, rx_sync = 1'b0;
  logic [23:0] tx_data = '0;
  logic [2:0]  sd = '0;
  logic [2:0]  oe_n, rx_valid;
  logic [23:0] rx_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pcm_serial_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .burst_mode_i(burst_mode), .pwr_up_i(pwr_up),
    .ch_en_i(ch_en), .tx_sync_i(tx_sync), .tx_data_i(tx_data), .tx_oe_no(oe_n),
    .rx_sync_i(rx_sync), .rx_sd_i(sd), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  // {burst, pwr, en[2:0], tx{ch2,ch1,ch0}, rx{ch2,ch1,ch0}}
  localparam logic [52:0] VEC [6] = '{
    {1'b0, 1'b1, 3'b111, 24'h81_3C_A5, 24'h7E_C3_5A},
    {1'b0, 1'b1, 3'b101, 24'hFE_12_00, 24'h01_00_FF},
    {1'b1, 1'b1, 3'b111, 24'hF0_0F_96, 24'hCC_33_69},
    {1'b1, 1'b1, 3'b010, 24'h7F_AA_55, 24'h7F_01_80},
    {1'b0, 1'b0, 3'b111, 24'h00_00_00, 24'h33_22_11},
    {1'b1, 1'b1, 3'b100, 24'h00_00_00, 24'hA5_5A_0F}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_oe(input bit mode, input bit pwr0, input bit pwr_now,
                                        input logic [2:0] en, input logic [23:0] tx,
                                        input int b, input int n);
    logic [2:0] r = 3'b111;
    logic [7:0] code;
    if (b < n && pwr_now) begin
      if (mode) begin
        code = (pwr0 && en[b/8]) ? tx[(b/8)*8 +: 8] : 8'hFF;
        r[0] = code[7 - b%8];
      end else begin
        for (int c = 0; c < 3; c++) begin
          code = (pwr0 && en[c]) ? tx[c*8 +: 8] : 8'hFF;
          r[c] = code[7 - b];
        end
      end
    end
    return r;
  endfunction

  task automatic run_frame(input bit mode, input bit pwr, input logic [2:0] en,
                           input logic [23:0] tx, input logic [23:0] rx,
                           input int hold, input int drop);
    int n = mode ? 24 : 8;
    bit pwr_now = pwr;
    @(negedge clk);
    burst_mode = mode; pwr_up = pwr; ch_en = en; tx_data = tx;
    tx_sync = 1'b1; rx_sync = 1'b1; sd = '0;
    for (int b = 0; b <= n + 4; b++) begin
      @(negedge clk);
      if (b == 0) tx_data = ~tx;  // R3: late change must not reach this frame
      if (b >= hold) begin tx_sync = 1'b0; rx_sync = 1'b0; end
      if (b == drop) begin pwr_up = 1'b0; pwr_now = 1'b0; #1; end
      begin
        logic [2:0] e = exp_oe(mode, pwr, pwr_now, en, tx, b, n);
        string tag = (b >= n) ? ((hold > n) ? "R9" : "R5") :
                     (!pwr_now ? "R6" : (mode ? "R2" : ((en != 3'b111) ? "R7" : "R1")));
        chk(oe_n === e, tag, oe_n, e);
      end
      for (int c = 0; c < 3; c++) begin
        bit ev = mode ? (b == (c + 1) * 8) : (b == 8);
        chk(rx_valid[c] === ev, "R4 valid", rx_valid[c], ev);
        if (ev) chk(rx_data[c*8 +: 8] === rx[c*8 +: 8], mode ? "R2 rx" : "R4 rx",
                    rx_data[c*8 +: 8], rx[c*8 +: 8]);
      end
      if (b < n) begin
        if (mode) begin
          sd[0] = rx[(b/8)*8 + 7 - b%8];
          sd[2:1] = {b[0], ~rx[(b/8)*8 + 7 - b%8]};  // R2: ignored lanes
        end else begin
          for (int c = 0; c < 3; c++) sd[c] = rx[c*8 + 7 - b];
        end
      end else begin
        sd = 3'b101;
      end
    end
    @(negedge clk);
    tx_sync = 1'b0; rx_sync = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8
    chk(oe_n === 3'b111, "R8 oe", oe_n, 3'b111);
    chk(rx_valid === 3'b000, "R8 valid", rx_valid, 0);
    chk(rx_data === 24'h0, "R8 data", rx_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe_n === 3'b111, "R8 oe", oe_n, 3'b111);

    for (int i = 0; i < 6; i++)
      run_frame(VEC[i][52], VEC[i][51], VEC[i][50:48], VEC[i][47:24], VEC[i][23:0], 1, -1);

    // R9: syncs held high past the slot
    run_frame(1'b0, 1'b1, 3'b111, 24'h00_0F_30, 24'h96_3C_E1, 12, -1);
    // R6: power dropped mid-slot on an all-zero frame
    run_frame(1'b0, 1'b1, 3'b111, 24'h00_00_00, 24'h12_34_56, 1, 3);
    pwr_up = 1'b1;
    run_frame(1'b1, 1'b1, 3'b111, 24'h00_00_00, 24'h0F_F0_3C, 1, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule